// File: doc/BRIEF.md
# Serial Flash Boot Image Loader

After reset is released, this block fetches a configuration image from an external serial flash and passes it, one byte at a time, to an on-chip configuration consumer. It acts as the SPI master in mode 0 and uses one fast-read command (opcode 0x0B) followed by a 24-bit start address and a single dummy byte. It then keeps the clock running under one chip-select assertion while the flash advances its own address, and stops when a fixed number of bytes has been delivered.

The SPI clock is the system clock divided by a fixed even integer. With a 200 MHz system clock and the default divider of 6, the SPI clock is 33.3 MHz. It never adapts to the attached flash and never issues the plain read command. The consumer uses a valid/ready byte interface. While the consumer holds ready low, the SPI clock stays parked low between bytes and chip select stays asserted. A status output, `init_busy`, is high from reset until the last image byte has been accepted, and then drops for good. The start address, byte count, clock divider and the minimum chip-select idle time before the transfer are all parameters. A byte count of zero finishes at once and never selects the flash.

Top module: `flash_boot_loader`

## Requirements
- R1: Mode 0 framing. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` never changes while `spi_sclk` is high. MISO is sampled when `spi_sclk` rises.
- R2: The first byte shifted out after `spi_cs_n` falls is 0x0B, most significant bit first.
- R3: The next three bytes are `BASE_ADDR[23:16]`, `BASE_ADDR[15:8]` and `BASE_ADDR[7:0]`, each MSB first. One dummy byte follows, and read data starts with the byte after the dummy.
- R4: Within a byte, consecutive rising edges of `spi_sclk` are exactly `SCLK_DIV` system clocks apart, with equal high and low phases.
- R5: Exactly one chip-select assertion covers the whole image: `spi_cs_n` falls once per boot.
- R6: Exactly `BYTE_COUNT` bytes are presented on `cfg_data`, in order. Byte k equals the flash content at address `BASE_ADDR + k`, assembled MSB first.
- R7: `init_busy` is 1 during reset and after release, and stays 1 up to and including the cycle in which the last byte is accepted. From the next clock on it is 0 and never rises again.
- R8: After reset release, `spi_cs_n` stays high for at least `CS_GAP` system clock edges before it first falls.
- R9: While `cfg_valid` is 1 and `cfg_ready` is 0, `spi_sclk` stays low, `spi_cs_n` stays low and `cfg_data` holds its value.
- R10: With `BYTE_COUNT` = 0, `init_busy` drops at the first clock after reset release and `spi_cs_n` is never asserted.
- R11: After completion, `spi_cs_n` stays high, `spi_sclk` stays low and `cfg_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Command/address data to the flash |
| spi_miso | input | 1 | Read data from the flash |
| cfg_valid | output | 1 | Image byte available |
| cfg_data | output | 8 | Image byte |
| cfg_ready | input | 1 | Consumer accepts the byte |
| init_busy | output | 1 | High while the boot load is in progress |

## Verification
The hardest condition to reach from the ports is a long consumer stall at a byte boundary in the middle of the read stream. During such a stall, a wrong design would let the serial clock run or drop chip select, and the flash would silently skip bytes. The bench holds `cfg_ready` low for dozens of cycles over three consecutive data bytes and randomises ready for the remaining bytes. A flash model reconstructs the command and address from the pins and serves addressed content, so any lost or extra clock shows up as a data mismatch. The start address is placed just below a 256-byte boundary, so the data crosses a carry in the flash address. A second instance with a zero byte count covers the immediate-completion path.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam logic [7:0] OPC_FAST_READ = 8'h0B;
    localparam int unsigned HDR_LEN      = 5;   // opcode, 3 address bytes, dummy
    localparam logic [2:0] HDR_LAST      = 3'(HDR_LEN - 1);

    typedef enum logic [2:0] {
        ST_GAP  = 3'd0,
        ST_HDR  = 3'd1,
        ST_RD   = 3'd2,
        ST_HOLD = 3'd3,
        ST_DONE = 3'd4
    } seq_state_t;

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int unsigned HALF_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    localparam int unsigned PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);

    typedef struct packed {
        logic            active;
        logic            sclk;
        logic [PH_W-1:0] ph;
        logic [2:0]      bitn;
        logic [7:0]      tx;
        logic [7:0]      rx;
        logic            done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.active) begin
            if (start_i) begin
                eng_d.active = 1'b1;
                eng_d.sclk   = 1'b0;
                eng_d.ph     = '0;
                eng_d.bitn   = 3'd0;
                eng_d.tx     = tx_i;
            end
        end else if (eng_q.ph == PH_LAST) begin
            eng_d.ph = '0;
            if (!eng_q.sclk) begin
                // rising edge: capture the bit the flash presented
                eng_d.sclk = 1'b1;
                eng_d.rx   = {eng_q.rx[6:0], miso_i};
            end else begin
                // falling edge: advance the outgoing bit
                eng_d.sclk = 1'b0;
                eng_d.tx   = {eng_q.tx[6:0], 1'b0};
                if (eng_q.bitn == 3'd7) begin
                    eng_d.active = 1'b0;
                    eng_d.done   = 1'b1;
                end else begin
                    eng_d.bitn = eng_q.bitn + 3'd1;
                end
            end
        end else begin
            eng_d.ph = eng_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sclk_o = eng_q.sclk;
    assign mosi_o = eng_q.tx[7];
    assign done_o = eng_q.done;
    assign rx_o   = eng_q.rx;

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_pkg::*;
#(
    parameter int unsigned CS_GAP     = 20,
    parameter logic [23:0] BASE_ADDR  = 24'h000000,
    parameter int unsigned BYTE_COUNT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_done_i,
    input  logic [7:0] eng_rx_i,
    input  logic       sink_ready_i,
    output logic       eng_start_o,
    output logic [7:0] eng_tx_o,
    output logic       cs_n_o,
    output logic       busy_o,
    output logic       valid_o,
    output logic [7:0] data_o
);

    localparam int unsigned GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'((CS_GAP > 0) ? CS_GAP - 1 : 0);
    localparam int unsigned CNT_W = (BYTE_COUNT > 1) ? $clog2(BYTE_COUNT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((BYTE_COUNT > 0) ? BYTE_COUNT - 1 : 0);
    localparam bit EMPTY_IMAGE = (BYTE_COUNT == 0);

    // command header bytes, indexed by header position
    logic [7:0] hdr_rom [8];

    for (genvar gi = 0; gi < 8; gi++) begin : g_hdr
        if (gi == 0) begin : g_opc
            assign hdr_rom[gi] = OPC_FAST_READ;
        end else if (gi < 4) begin : g_addr
            assign hdr_rom[gi] = BASE_ADDR[23 - 8*(gi-1) -: 8];
        end else begin : g_pad
            assign hdr_rom[gi] = 8'h00;
        end
    end

    typedef struct packed {
        seq_state_t       st;
        logic [GAP_W-1:0] gap;
        logic [2:0]       hdr;
        logic             launched;
        logic [CNT_W-1:0] cnt;
        logic             cs_n;
        logic             busy;
        logic             valid;
        logic [7:0]       data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        eng_start_o = 1'b0;
        eng_tx_o    = 8'h00;
        unique case (seq_q.st)
            ST_GAP: begin
                if (EMPTY_IMAGE) begin
                    seq_d.st   = ST_DONE;
                    seq_d.busy = 1'b0;
                end else if (seq_q.gap == GAP_LAST) begin
                    seq_d.st   = ST_HDR;
                    seq_d.cs_n = 1'b0;
                    seq_d.hdr  = 3'd0;
                end else begin
                    seq_d.gap = seq_q.gap + 1'b1;
                end
            end
            ST_HDR: begin
                eng_tx_o = hdr_rom[seq_q.hdr];
                if (!seq_q.launched) begin
                    eng_start_o    = 1'b1;
                    seq_d.launched = 1'b1;
                end else if (eng_done_i) begin
                    seq_d.launched = 1'b0;
                    if (seq_q.hdr == HDR_LAST) seq_d.st  = ST_RD;
                    else                       seq_d.hdr = seq_q.hdr + 3'd1;
                end
            end
            ST_RD: begin
                if (!seq_q.launched) begin
                    eng_start_o    = 1'b1;
                    seq_d.launched = 1'b1;
                end else if (eng_done_i) begin
                    seq_d.launched = 1'b0;
                    seq_d.data     = eng_rx_i;
                    seq_d.valid    = 1'b1;
                    seq_d.st       = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (sink_ready_i) begin
                    seq_d.valid = 1'b0;
                    if (seq_q.cnt == CNT_LAST) begin
                        seq_d.st   = ST_DONE;
                        seq_d.cs_n = 1'b1;
                        seq_d.busy = 1'b0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                        seq_d.st  = ST_RD;
                    end
                end
            end
            ST_DONE: begin
                seq_d.cs_n  = 1'b1;
                seq_d.valid = 1'b0;
                seq_d.busy  = 1'b0;
            end
            default: seq_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= '0;
            seq_q.st       <= ST_GAP;
            seq_q.cs_n     <= 1'b1;
            seq_q.busy     <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o  = seq_q.cs_n;
    assign busy_o  = seq_q.busy;
    assign valid_o = seq_q.valid;
    assign data_o  = seq_q.data;

endmodule

// File: rtl/flash_boot_loader.sv
module flash_boot_loader #(
    parameter int unsigned SCLK_DIV   = 6,
    parameter int unsigned CS_GAP     = 20,
    parameter logic [23:0] BASE_ADDR  = 24'h000000,
    parameter int unsigned BYTE_COUNT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       cfg_valid,
    output logic [7:0] cfg_data,
    input  logic       cfg_ready,
    output logic       init_busy
);

    localparam int unsigned HALF_CYC = (SCLK_DIV >= 2) ? SCLK_DIV / 2 : 1;

    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;

    spi_shift_engine #(
        .HALF_CYC (HALF_CYC)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .tx_i    (eng_tx),
        .miso_i  (spi_miso),
        .sclk_o  (spi_sclk),
        .mosi_o  (spi_mosi),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

    boot_sequencer #(
        .CS_GAP     (CS_GAP),
        .BASE_ADDR  (BASE_ADDR),
        .BYTE_COUNT (BYTE_COUNT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .eng_done_i   (eng_done),
        .eng_rx_i     (eng_rx),
        .sink_ready_i (cfg_ready),
        .eng_start_o  (eng_start),
        .eng_tx_o     (eng_tx),
        .cs_n_o       (spi_cs_n),
        .busy_o       (init_busy),
        .valid_o      (cfg_valid),
        .data_o       (cfg_data)
    );

endmodule

// File: rtl/boot_loader_checker.sv
module boot_loader_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       spi_miso,
    input logic       cfg_valid,
    input logic [7:0] cfg_data,
    input logic       cfg_ready,
    input logic       init_busy
);

    assert_sclk_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_steady_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_sclk) && spi_sclk) |-> $stable(spi_mosi));

    assert_busy_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |=> !init_busy);

    assert_stall_parks_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (!spi_sclk && !spi_cs_n));

    assert_stall_holds_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

    assert_quiet_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |-> (spi_cs_n && !spi_sclk && !cfg_valid));

endmodule

bind flash_boot_loader boot_loader_checker u_chk (.*);

// File: tb/tb_flash_boot_loader.sv
module tb_flash_boot_loader;

    localparam int unsigned SCLK_DIV = 6;
    localparam int unsigned CS_GAP   = 20;
    localparam logic [23:0] BASE     = 24'h1234F8;
    localparam int unsigned NBYTES   = 40;
    localparam int unsigned WD_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;
    logic       cfg_valid;
    logic [7:0] cfg_data;
    logic       cfg_ready = 1'b0;
    logic       init_busy;

    logic       z_sclk, z_cs_n, z_mosi, z_valid, z_busy;
    logic [7:0] z_data;

    flash_boot_loader #(
        .SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP), .BASE_ADDR(BASE), .BYTE_COUNT(NBYTES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_valid(cfg_valid),
        .cfg_data(cfg_data), .cfg_ready(cfg_ready), .init_busy(init_busy)
    );

    flash_boot_loader #(
        .SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP), .BASE_ADDR(BASE), .BYTE_COUNT(0)
    ) dut_zero (
        .clk(clk), .rst_n(rst_n), .spi_sclk(z_sclk), .spi_cs_n(z_cs_n),
        .spi_mosi(z_mosi), .spi_miso(1'b0), .cfg_valid(z_valid),
        .cfg_data(z_data), .cfg_ready(1'b1), .init_busy(z_busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // pin-level observation state
    int         rel_cyc = 0;
    int         gap_seen = -1;
    int         cs_falls = 0;
    int         r1_viol = 0;
    int         r9_viol = 0;
    int         r7_viol = 0;
    int         stall_cycles = 0;
    int         z_cs_low = 0;
    int         bitcnt = 0;
    int         rise_a = -1;
    int         rise_b = -1;
    logic [7:0] opc_seen = 8'h00;
    logic [23:0] addr_seen = 24'h0;
    logic [7:0] rx_store [NBYTES];
    int         got = 0;
    int         hold_ctr = 0;
    bit         last_acc = 1'b0;
    bit         prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0, prev_stall = 1'b0;
    logic [7:0] stall_data = 8'h00;

    always @(negedge clk) begin
        if (!rst_n) begin
            rel_cyc   = 0;
            prev_sclk = 1'b0;
            prev_cs   = 1'b1;
        end else begin
            rel_cyc++;
            if (gap_seen < 0 && !spi_cs_n) gap_seen = rel_cyc;
            if (prev_cs && !spi_cs_n) cs_falls++;
            if (!z_cs_n) z_cs_low++;
            // R1: mode 0 framing
            if (spi_cs_n && spi_sclk) r1_viol++;
            if (prev_sclk && spi_sclk && (spi_mosi != prev_mosi)) r1_viol++;
            // flash model
            if (spi_cs_n) bitcnt = 0;
            else if (!prev_sclk && spi_sclk) begin
                if (rise_a < 0) rise_a = rel_cyc;
                else if (rise_b < 0) rise_b = rel_cyc;
                if (bitcnt < 8)       opc_seen  = {opc_seen[6:0], spi_mosi};
                else if (bitcnt < 32) addr_seen = {addr_seen[22:0], spi_mosi};
                bitcnt++;
            end else if (prev_sclk && !spi_sclk && bitcnt >= 40) begin
                automatic int idx = bitcnt - 40;
                automatic logic [7:0] fb = flash_byte(addr_seen + 24'(idx / 8));
                spi_miso = fb[7 - (idx % 8)];
            end
            // R7: status stays busy while bytes remain
            if (last_acc) begin
                check(!init_busy && spi_cs_n, "R7 busy drops after last accept",
                      {init_busy, spi_cs_n}, 2'b01);
                last_acc = 1'b0;
            end else if (got < NBYTES && !init_busy) r7_viol++;
            // R9: stall behaviour
            if (prev_stall && cfg_data != stall_data) r9_viol++;
            // sink
            if (got >= 6 && got < 9) cfg_ready = (hold_ctr >= 45);
            else                     cfg_ready = (($urandom % 10) < 7);
            prev_stall = cfg_valid && !cfg_ready;
            if (prev_stall) begin
                stall_cycles++;
                hold_ctr++;
                stall_data = cfg_data;
                if (spi_sclk || spi_cs_n) r9_viol++;
            end
            if (cfg_valid && cfg_ready) begin
                if (got < NBYTES) rx_store[got] = cfg_data;
                if (got == NBYTES - 1) begin
                    check(init_busy == 1'b1, "R7 busy held through last accept", init_busy, 1);
                    last_acc = 1'b1;
                end
                got++;
                hold_ctr = 0;
            end
            prev_sclk = spi_sclk;
            prev_cs   = spi_cs_n;
            prev_mosi = spi_mosi;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // reset state
        check(spi_cs_n == 1'b1, "R1 cs high in reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R1 sclk low in reset", spi_sclk, 0);
        check(init_busy == 1'b1, "R7 busy high in reset", init_busy, 1);
        check(cfg_valid == 1'b0, "R11 no valid in reset", cfg_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(init_busy == 1'b1, "R7 busy high after release", init_busy, 1);
        check(z_busy == 1'b0, "R10 zero count done at first clock", z_busy, 0);
        while (init_busy && rel_cyc < WD_LIMIT) @(negedge clk);
        if (init_busy) check(1'b0, "watchdog expired", rel_cyc, WD_LIMIT);
        repeat (100) @(negedge clk);

        check(gap_seen >= int'(CS_GAP), "R8 cs idle before first fall", gap_seen, CS_GAP);
        check(opc_seen == 8'h0B, "R2 opcode", opc_seen, 8'h0B);
        check(addr_seen == BASE, "R3 start address", addr_seen, BASE);
        check((rise_b - rise_a) == int'(SCLK_DIV), "R4 sclk period", rise_b - rise_a, SCLK_DIV);
        check(cs_falls == 1, "R5 single chip select", cs_falls, 1);
        check(got == int'(NBYTES), "R6 byte count", got, NBYTES);
        for (int k = 0; k < int'(NBYTES); k++) begin
            automatic logic [7:0] e = flash_byte(BASE + 24'(k));
            check(rx_store[k] == e, $sformatf("R6 data byte %0d (dummy R3)", k), rx_store[k], e);
        end
        check(r1_viol == 0, "R1 mode 0 framing violations", r1_viol, 0);
        check(r7_viol == 0, "R7 early busy drop", r7_viol, 0);
        check(stall_cycles > 100, "R9 stall exercised", stall_cycles, 100);
        check(r9_viol == 0, "R9 stall violations", r9_viol, 0);
        check(spi_cs_n && !spi_sclk && !cfg_valid && !init_busy, "R11 idle after done",
              {spi_cs_n, spi_sclk, cfg_valid, init_busy}, 4'b1000);
        check(z_cs_low == 0, "R10 zero count never selects", z_cs_low, 0);
        check(!z_busy && !z_valid, "R10 zero count stays idle", {z_busy, z_valid}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule